// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sits beside a small microcontroller core and decides what happens when the core decodes a sleep instruction. Two register bits qualify the instruction: an idle-enable bit and a two-bit clock-source select. Together they choose between stopping only the CPU (Idle) and shutting down the fast clocks entirely (Sleep). The controller drives registered enables for the CPU clock, the peripheral clock and each oscillator. It also keeps three clock-source status flags.

Three events bring the device back: an enabled interrupt, a watchdog time-out or a reset. The wake path is Sleep to Wake to Run. In Wake the CPU runs again at once, the primary oscillator is restarted, and the primary-ready flag stays low until the oscillator reports it is ready. Idle returns straight to Run, because its clocks never stopped. One-cycle pulses tell the core how to resume: take the interrupt vector, fall through to the next instruction, or note a watchdog wake.

States: RUN (encoding 0), IDLE (1), SLEEP (2), WAKE (3). Transitions:
- RUN→IDLE: sleep with idle-enable set.
- RUN→SLEEP: sleep with idle-enable clear and select 00.
- IDLE→RUN: on a wake event.
- SLEEP→WAKE: on a wake event.
- WAKE→RUN: on an oscillator-ready pulse.
- Any state→RUN: on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in RUN: `mode`=0, all five clock/oscillator enables are 1, the three status flags are 0 and the three wake pulses are 0. `mode` encodes RUN=0, IDLE=1, SLEEP=2, WAKE=3.
- R2: If `sleep_exec` is high in RUN with `idle_en`=1, then at that clock edge `mode` becomes IDLE, `cpu_clk_en` drops to 0, and `periph_clk_en`, `pri_osc_en` and `int_osc_en` stay 1. The status flags keep their values for the whole stay in IDLE.
- R3: If `sleep_exec` is high in RUN with `idle_en`=0 and `clk_sel`=2'b00, then at that edge `mode` becomes SLEEP. `cpu_clk_en`, `periph_clk_en`, `pri_osc_en` and `int_osc_en` go to 0, and `pri_rdy`, `int_stable` and `sec_running` are cleared.
- R4: In SLEEP, `lfrc_en` equals `wdt_en` as sampled at the previous edge. In every state, `sec_osc_en` equals `sec_osc_cfg` as sampled at the previous edge. Outside SLEEP, `lfrc_en` is 1.
- R5: A sleep with `idle_en`=0 and `clk_sel`≠2'b00 has no effect: `mode` stays RUN and `cpu_clk_en` stays 1. `sleep_exec` is also ignored in IDLE, SLEEP and WAKE.
- R6: An interrupt wakes the controller only when some bit i has both `irq_flag[i]` and `irq_en[i]` set. Flags whose enable is clear leave IDLE and SLEEP unchanged.
- R7: On leaving IDLE or SLEEP because of an interrupt, exactly one of two pulses is high for one cycle: `wake_vector` if `gie`=1, or `wake_resume` if `gie`=0. The pulse is high in the cycle after the wake edge.
- R8: `wdt_timeout` in IDLE or SLEEP causes a wake and raises `wake_wdt` for one cycle. A watchdog time-out in RUN or WAKE produces no pulse.
- R9: A wake from SLEEP enters WAKE. There `cpu_clk_en`, `periph_clk_en`, `pri_osc_en` and `int_osc_en` are 1 and `pri_rdy` stays 0. The first `osc_ready` pulse moves the controller to RUN and sets `pri_rdy` at the same edge. A wake from IDLE goes directly to RUN.
- R10: In RUN and WAKE, `osc_ready` sets `pri_rdy` and `intosc_ready` sets `int_stable`. `sec_running` follows (`clk_sel`==2'b01 && `sec_osc_cfg`) one edge later. None of these flags is set while in SLEEP or IDLE.
- R11: An asynchronous reset from any state returns all outputs to the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec | input | 1 | Sleep instruction decoded this cycle |
| idle_en | input | 1 | Idle-enable bit |
| clk_sel | input | 2 | Clock-source select field |
| wdt_en | input | 1 | Watchdog enable (keeps low-frequency RC alive in Sleep) |
| sec_osc_cfg | input | 1 | Secondary timer oscillator enable bit |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | IRQ_W | Interrupt source flags |
| irq_en | input | IRQ_W | Per-source interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out event |
| osc_ready | input | 1 | Primary oscillator ready pulse |
| intosc_ready | input | 1 | Internal oscillator stable pulse |
| mode | output | 2 | Current state (RUN=0, IDLE=1, SLEEP=2, WAKE=3) |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| int_osc_en | output | 1 | Internal oscillator block enable |
| lfrc_en | output | 1 | Low-frequency RC oscillator enable |
| sec_osc_en | output | 1 | Secondary timer oscillator enable |
| pri_rdy | output | 1 | Primary-oscillator-ready flag |
| int_stable | output | 1 | Internal-oscillator-stable flag |
| sec_running | output | 1 | Secondary oscillator running as clock source flag |
| wake_vector | output | 1 | Interrupt wake, branch to vector |
| wake_resume | output | 1 | Interrupt wake, continue without branch |
| wake_wdt | output | 1 | Watchdog caused the wake |

## Verification
Several events can land on the same edge. A watchdog time-out and an enabled interrupt can both arrive in one cycle of IDLE or SLEEP; in that case `wake_wdt` and one of the interrupt pulses must both be high. A sleep instruction can coincide with a pending interrupt, and an oscillator-ready pulse can coincide with the sleep that moves the controller into IDLE. The random stimulus raises every input independently each cycle, so these overlaps occur many times. A cycle-accurate bench model built from the requirements decides, for each output, which event wins in each case.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_t;

    localparam logic [1:0] SEL_PRIMARY   = 2'b00;
    localparam logic [1:0] SEL_SECONDARY = 2'b01;
endpackage

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
    parameter int IRQ_W = 8
) (
    input  logic [IRQ_W-1:0] irq_flag,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             irq_wake,
    output logic             wdt_wake
);
    logic [IRQ_W-1:0] masked;

    for (genvar gi = 0; gi < IRQ_W; gi++) begin : g_mask
        assign masked[gi] = irq_flag[gi] & irq_en[gi];
    end

    assign irq_wake = |masked;
    assign wdt_wake = wdt_timeout;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_exec,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       irq_wake,
    input  logic       wdt_wake,
    input  logic       osc_ready,
    output pm_state_t  state,
    output pm_state_t  nxt
);
    logic wake_ev;
    assign wake_ev = irq_wake | wdt_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN: begin
                if (sleep_exec) begin
                    if (idle_en)                       nxt = PM_IDLE;
                    else if (clk_sel == SEL_PRIMARY)   nxt = PM_SLEEP;
                end
            end
            PM_IDLE:  if (wake_ev)   nxt = PM_RUN;
            PM_SLEEP: if (wake_ev)   nxt = PM_WAKE;
            PM_WAKE:  if (osc_ready) nxt = PM_RUN;
        endcase
    end
endmodule

// File: rtl/pmc_out_regs.sv
module pmc_out_regs
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pm_state_t  state,
    input  pm_state_t  nxt,
    input  logic       gie,
    input  logic       irq_wake,
    input  logic       wdt_wake,
    input  logic       wdt_en,
    input  logic       sec_osc_cfg,
    input  logic [1:0] clk_sel,
    input  logic       osc_ready,
    input  logic       intosc_ready,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       pri_osc_en,
    output logic       int_osc_en,
    output logic       lfrc_en,
    output logic       sec_osc_en,
    output logic       pri_rdy,
    output logic       int_stable,
    output logic       sec_running,
    output logic       wake_vector,
    output logic       wake_resume,
    output logic       wake_wdt
);
    logic leaving;
    logic awake_now;

    assign leaving   = ((state == PM_IDLE) || (state == PM_SLEEP)) && (nxt != state);
    assign awake_now = (state == PM_RUN) || (state == PM_WAKE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_en    <= 1'b1;
            periph_clk_en <= 1'b1;
            pri_osc_en    <= 1'b1;
            int_osc_en    <= 1'b1;
            lfrc_en       <= 1'b1;
            sec_osc_en    <= 1'b0;
            pri_rdy       <= 1'b0;
            int_stable    <= 1'b0;
            sec_running   <= 1'b0;
            wake_vector   <= 1'b0;
            wake_resume   <= 1'b0;
            wake_wdt      <= 1'b0;
        end else begin
            cpu_clk_en    <= (nxt == PM_RUN) || (nxt == PM_WAKE);
            periph_clk_en <= (nxt != PM_SLEEP);
            pri_osc_en    <= (nxt != PM_SLEEP);
            int_osc_en    <= (nxt != PM_SLEEP);
            lfrc_en       <= (nxt != PM_SLEEP) || wdt_en;
            sec_osc_en    <= sec_osc_cfg;
            wake_vector   <= leaving && irq_wake && gie;
            wake_resume   <= leaving && irq_wake && !gie;
            wake_wdt      <= leaving && wdt_wake;
            unique case (nxt)
                PM_SLEEP: begin
                    pri_rdy     <= 1'b0;
                    int_stable  <= 1'b0;
                    sec_running <= 1'b0;
                end
                PM_IDLE: begin
                    pri_rdy     <= pri_rdy;
                    int_stable  <= int_stable;
                    sec_running <= sec_running;
                end
                PM_RUN, PM_WAKE: begin
                    pri_rdy     <= pri_rdy    | (osc_ready    & awake_now);
                    int_stable  <= int_stable | (intosc_ready & awake_now);
                    sec_running <= (clk_sel == SEL_SECONDARY) && sec_osc_cfg;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_exec,
    input  logic             idle_en,
    input  logic [1:0]       clk_sel,
    input  logic             wdt_en,
    input  logic             sec_osc_cfg,
    input  logic             gie,
    input  logic [IRQ_W-1:0] irq_flag,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             osc_ready,
    input  logic             intosc_ready,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             pri_osc_en,
    output logic             int_osc_en,
    output logic             lfrc_en,
    output logic             sec_osc_en,
    output logic             pri_rdy,
    output logic             int_stable,
    output logic             sec_running,
    output logic             wake_vector,
    output logic             wake_resume,
    output logic             wake_wdt
);
    logic      irq_wake;
    logic      wdt_wake;
    pm_state_t state;
    pm_state_t nxt;

    pmc_wake_detect #(.IRQ_W(IRQ_W)) u_wake (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .irq_wake    (irq_wake),
        .wdt_wake    (wdt_wake)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_exec (sleep_exec),
        .idle_en    (idle_en),
        .clk_sel    (clk_sel),
        .irq_wake   (irq_wake),
        .wdt_wake   (wdt_wake),
        .osc_ready  (osc_ready),
        .state      (state),
        .nxt        (nxt)
    );

    pmc_out_regs u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .nxt           (nxt),
        .gie           (gie),
        .irq_wake      (irq_wake),
        .wdt_wake      (wdt_wake),
        .wdt_en        (wdt_en),
        .sec_osc_cfg   (sec_osc_cfg),
        .clk_sel       (clk_sel),
        .osc_ready     (osc_ready),
        .intosc_ready  (intosc_ready),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .pri_osc_en    (pri_osc_en),
        .int_osc_en    (int_osc_en),
        .lfrc_en       (lfrc_en),
        .sec_osc_en    (sec_osc_en),
        .pri_rdy       (pri_rdy),
        .int_stable    (int_stable),
        .sec_running   (sec_running),
        .wake_vector   (wake_vector),
        .wake_resume   (wake_resume),
        .wake_wdt      (wake_wdt)
    );

    assign mode = state;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_exec,
    input logic       osc_ready,
    input logic [1:0] mode,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       pri_osc_en,
    input logic       int_osc_en,
    input logic       pri_rdy,
    input logic       int_stable,
    input logic       sec_running,
    input logic       wake_vector,
    input logic       wake_resume
);
    localparam logic [1:0] M_RUN   = 2'd0;
    localparam logic [1:0] M_IDLE  = 2'd1;
    localparam logic [1:0] M_SLEEP = 2'd2;
    localparam logic [1:0] M_WAKE  = 2'd3;

    p_idle_cpu_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE) |-> (!cpu_clk_en && periph_clk_en && pri_osc_en && int_osc_en));

    p_idle_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE && $past(mode) == M_IDLE) |-> $stable({pri_rdy, int_stable, sec_running}));

    p_sleep_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SLEEP) |-> (!cpu_clk_en && !periph_clk_en && !pri_osc_en && !int_osc_en
                               && !pri_rdy && !int_stable && !sec_running));

    p_run_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && !sleep_exec) |=> (mode == M_RUN));

    p_wake_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_vector, wake_resume}));

    p_wake_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WAKE) |-> (cpu_clk_en && pri_osc_en && int_osc_en && !pri_rdy));

    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WAKE && osc_ready) |=> (mode == M_RUN && pri_rdy));

    p_rdy_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_rdy) |-> $past(osc_ready));
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_exec    (sleep_exec),
    .osc_ready     (osc_ready),
    .mode          (mode),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .pri_osc_en    (pri_osc_en),
    .int_osc_en    (int_osc_en),
    .pri_rdy       (pri_rdy),
    .int_stable    (int_stable),
    .sec_running   (sec_running),
    .wake_vector   (wake_vector),
    .wake_resume   (wake_resume)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/100ps
module pwr_mode_ctrl_test;
    localparam int IRQ_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_exec = 1'b0;
    logic             idle_en = 1'b0;
    logic [1:0]       clk_sel = 2'b00;
    logic             wdt_en = 1'b0;
    logic             sec_osc_cfg = 1'b0;
    logic             gie = 1'b0;
    logic [IRQ_W-1:0] irq_flag = '0;
    logic [IRQ_W-1:0] irq_en = '0;
    logic             wdt_timeout = 1'b0;
    logic             osc_ready = 1'b0;
    logic             intosc_ready = 1'b0;
    logic [1:0]       mode;
    logic cpu_clk_en, periph_clk_en, pri_osc_en, int_osc_en, lfrc_en, sec_osc_en;
    logic pri_rdy, int_stable, sec_running, wake_vector, wake_resume, wake_wdt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int e_mode;
    bit e_cpu, e_per, e_pri, e_int, e_lfrc, e_sec, e_rdy, e_stb, e_srun, e_vec, e_res, e_wdt;

    pwr_mode_ctrl #(.IRQ_W(IRQ_W)) uut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_mode = 0; e_cpu = 1; e_per = 1; e_pri = 1; e_int = 1; e_lfrc = 1; e_sec = 0;
        e_rdy = 0; e_stb = 0; e_srun = 0; e_vec = 0; e_res = 0; e_wdt = 0;
    endtask

    // next expected outputs from the requirements, using inputs present at the coming edge
    task automatic model_step();
        int nx;
        bit irqw, wake, leave, awake;
        irqw  = |(irq_flag & irq_en);
        wake  = irqw || wdt_timeout;
        nx    = e_mode;
        case (e_mode)
            0: if (sleep_exec) begin
                   if (idle_en) nx = 1;
                   else if (clk_sel == 2'b00) nx = 2;
               end
            1: if (wake) nx = 0;
            2: if (wake) nx = 3;
            default: if (osc_ready) nx = 0;
        endcase
        leave = (e_mode == 1 || e_mode == 2) && (nx != e_mode);
        awake = (e_mode == 0 || e_mode == 3);
        e_vec  = leave && irqw && gie;
        e_res  = leave && irqw && !gie;
        e_wdt  = leave && wdt_timeout;
        e_cpu  = (nx == 0 || nx == 3);
        e_per  = (nx != 2);
        e_pri  = (nx != 2);
        e_int  = (nx != 2);
        e_lfrc = (nx != 2) || wdt_en;
        e_sec  = sec_osc_cfg;
        if (nx == 2) begin
            e_rdy = 0; e_stb = 0; e_srun = 0;
        end else if (nx != 1) begin
            if (osc_ready && awake)    e_rdy = 1;
            if (intosc_ready && awake) e_stb = 1;
            e_srun = (clk_sel == 2'b01) && sec_osc_cfg;
        end
        e_mode = nx;
    endtask

    task automatic check_all(input string tag);
        chk(tag == "" ? "R9"  : tag, "mode",        int'(mode),          e_mode);
        chk(tag == "" ? "R2"  : tag, "cpu_clk_en",  int'(cpu_clk_en),    int'(e_cpu));
        chk(tag == "" ? "R3"  : tag, "periph",      int'(periph_clk_en), int'(e_per));
        chk(tag == "" ? "R3"  : tag, "pri_osc_en",  int'(pri_osc_en),    int'(e_pri));
        chk(tag == "" ? "R3"  : tag, "int_osc_en",  int'(int_osc_en),    int'(e_int));
        chk(tag == "" ? "R4"  : tag, "lfrc_en",     int'(lfrc_en),       int'(e_lfrc));
        chk(tag == "" ? "R4"  : tag, "sec_osc_en",  int'(sec_osc_en),    int'(e_sec));
        chk(tag == "" ? "R10" : tag, "pri_rdy",     int'(pri_rdy),       int'(e_rdy));
        chk(tag == "" ? "R10" : tag, "int_stable",  int'(int_stable),    int'(e_stb));
        chk(tag == "" ? "R10" : tag, "sec_running", int'(sec_running),   int'(e_srun));
        chk(tag == "" ? "R7"  : tag, "wake_vector", int'(wake_vector),   int'(e_vec));
        chk(tag == "" ? "R7"  : tag, "wake_resume", int'(wake_resume),   int'(e_res));
        chk(tag == "" ? "R8"  : tag, "wake_wdt",    int'(wake_wdt),      int'(e_wdt));
    endtask

    task automatic clear_in();
        sleep_exec = 0; irq_flag = '0; wdt_timeout = 0; osc_ready = 0; intosc_ready = 0;
    endtask

    // inputs already set; advance one edge and compare
    task automatic step(input string tag);
        model_step();
        @(negedge clk);
        check_all(tag);
        clear_in();
    endtask

    task automatic do_reset(input string tag);
        rst_n = 0;
        #0.5;
        model_reset();
        check_all(tag);
        #0.5;
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        @(negedge clk);
        check_all("R1");
        chk("R1", "mode after reset", int'(mode), 0);
        rst_n = 1;
        irq_en = 8'h0F;

        // R10: bring up flags in RUN
        osc_ready = 1; intosc_ready = 1; clk_sel = 2'b01; sec_osc_cfg = 1; step("R10");
        chk("R10", "pri_rdy set", int'(pri_rdy), 1);
        chk("R10", "sec_running", int'(sec_running), 1);

        // R2: enter IDLE, flags kept; R6: masked flag ignored
        sleep_exec = 1; idle_en = 1; step("R2");
        chk("R2", "mode idle", int'(mode), 1);
        chk("R2", "cpu off in idle", int'(cpu_clk_en), 0);
        irq_flag = 8'hF0; step("R6");
        chk("R6", "masked irq stays idle", int'(mode), 1);
        // R7 vector wake from IDLE, R9 direct return
        irq_flag = 8'h01; gie = 1; step("R7");
        chk("R7", "wake_vector", int'(wake_vector), 1);
        chk("R9", "idle to run", int'(mode), 0);
        step("R7");
        chk("R7", "pulse one cycle", int'(wake_vector), 0);

        // R5: sleep with nonzero select ignored
        idle_en = 0; clk_sel = 2'b10; sleep_exec = 1; step("R5");
        chk("R5", "still run", int'(mode), 0);
        chk("R5", "cpu still on", int'(cpu_clk_en), 1);

        // R3/R4: SLEEP entry
        clk_sel = 2'b00; wdt_en = 1; sec_osc_cfg = 1; sleep_exec = 1; step("R3");
        chk("R3", "mode sleep", int'(mode), 2);
        chk("R3", "pri_rdy cleared", int'(pri_rdy), 0);
        chk("R4", "lfrc alive with wdt", int'(lfrc_en), 1);
        wdt_en = 0; step("R4");
        chk("R4", "lfrc off without wdt", int'(lfrc_en), 0);
        // R8 + R7 coincide: watchdog and irq in same cycle, gie=0
        gie = 0; wdt_timeout = 1; irq_flag = 8'h02; step("R8");
        chk("R8", "wake_wdt", int'(wake_wdt), 1);
        chk("R7", "wake_resume", int'(wake_resume), 1);
        chk("R9", "sleep to wake", int'(mode), 3);
        for (int i = 0; i < 4; i++) step("R9");
        chk("R9", "waiting for osc", int'(mode), 3);
        chk("R9", "rdy low in wake", int'(pri_rdy), 0);
        osc_ready = 1; step("R9");
        chk("R9", "wake to run", int'(mode), 0);
        chk("R9", "rdy set on exit", int'(pri_rdy), 1);

        // R11: reset from SLEEP
        sleep_exec = 1; step("R3");
        @(negedge clk);
        do_reset("R11");
        chk("R11", "run after reset", int'(mode), 0);

        // random phase
        for (int n = 0; n < 20000; n++) begin
            if ($urandom % 500 == 0) do_reset("R11");
            sleep_exec   = ($urandom % 6 == 0);
            idle_en      = $urandom % 2;
            clk_sel      = 2'($urandom % 4);
            wdt_en       = $urandom % 2;
            sec_osc_cfg  = $urandom % 2;
            gie          = $urandom % 2;
            irq_en       = 8'($urandom);
            irq_flag     = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
            wdt_timeout  = ($urandom % 12 == 0);
            osc_ready    = ($urandom % 5 == 0);
            intosc_ready = ($urandom % 7 == 0);
            step("");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule